// File: doc/BRIEF.md
# Two-Wire Bus Master Transmitter

This block is the transmit half of a two-wire serial bus master, run by software through three registers: a control register, a data register and a status register. Software asks for a START condition and then sends a slave address with the write bit, followed by any number of data bytes. It can finish the transfer with a STOP condition. Each bus step ends the same way. The controller raises a handshake flag, posts a status code and holds SCL low. It does nothing more until software writes a one to the flag bit.

The bus pins are modelled as open-drain enables (`scl_oe`/`sda_oe` high pulls the line low). The line levels come back on `scl_in`/`sda_in`. SCL timing comes from a quarter-period divider parameter `QDIV`. A data bit spends two quarters with SCL low and two with SCL high. SDA changes only at the end of the first low quarter, and SDA is sampled at the end of the first high quarter.

Top module: `i2c_mtx_ctrl`

## Requirements
- R1: After reset the flag is low, the status reads 0xF8, both open-drain enables are off and the control readback is 0x00.
- R2: A control write (`reg_sel`=0) with bit 7 (flag clear), bit 5 (start) and bit 2 (enable) all set creates a START, which is SDA falling while SCL is high. After it, the flag rises with status 0x08. A control write with bit 2 clear has no effect on the bus or the flag.
- R3: The controller watches the bus for START and STOP conditions made by other masters. A START request made while the bus is busy is held off, with both lines released and the flag low, until a STOP is seen.
- R4: The address byte and data bytes are sent MSB first. SDA changes only while SCL is low. After the address byte, status 0x18 means ACK (SDA low in the ninth bit) and 0x20 means NACK.
- R5: After a data byte, status 0x28 means ACK and 0x30 means NACK.
- R6: Writing a one to control bit 7 clears the flag. The flag never falls in any other way. While the flag is high after any code other than 0x38, SCL is held low.
- R7: A data write (`reg_sel`=1) made while the flag is low is discarded, and it sets the collision bit (control readback bit 3). A data write made while the flag is high loads the byte and clears the collision bit.
- R8: A control write with bit 7, bit 4 (stop) and bit 2 set creates a STOP, which is SDA rising while SCL is high. Bit 4 of the readback stays one until the STOP is finished and then clears by itself. The flag is not set afterwards.
- R9: Arbitration is lost when the controller releases SDA for a one but samples it low while SCL is high. The controller then releases both lines and raises the flag with status 0x38. After the loss, a new START request is accepted.
- R10: The three low bits of the status output are always zero. The status reads 0xF8 whenever the flag is low.
- R11: During a bit, the SCL high phase lasts exactly 2*`QDIV` clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects control, 1 selects data |
| reg_wdata | input | 8 | Write data |
| ctrl_rd | output | 8 | Control readback {flag,0,start,stop,collision,enable,0,0} |
| data_rd | output | 8 | Data register readback |
| status | output | 8 | Status code, low three bits zero |
| irq | output | 1 | Handshake flag |
| scl_in | input | 1 | Sensed SCL level |
| sda_in | input | 1 | Sensed SDA level |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |

## Verification
Two pairs of events can land in the same window. The first pair is a START request and a START from another master. The bench pulls SDA low as another master would, issues a START request, and checks that the lines stay released and the flag stays low until it lets SDA go high again. The second pair is the controller releasing SDA for a one while another device pulls it low in the same SCL high phase. The bench's slave model drives SDA low at a chosen bit of a data byte. The result is judged from status 0x38, from both enables being off, and from a new START that follows normally.

// File: rtl/i2c_mtx_pkg.sv
package i2c_mtx_pkg;
  localparam int DW = 8;

  // control register bit positions
  localparam int B_FLAG  = 7;
  localparam int B_START = 5;
  localparam int B_STOP  = 4;
  localparam int B_WCOL  = 3;
  localparam int B_EN    = 2;

  localparam logic [DW-1:0] ST_START = 8'h08;
  localparam logic [DW-1:0] ST_AACK  = 8'h18;
  localparam logic [DW-1:0] ST_ANACK = 8'h20;
  localparam logic [DW-1:0] ST_DACK  = 8'h28;
  localparam logic [DW-1:0] ST_DNACK = 8'h30;
  localparam logic [DW-1:0] ST_ARB   = 8'h38;
  localparam logic [DW-1:0] ST_NONE  = 8'hF8;

  typedef enum logic [3:0] {
    E_IDLE, E_RS0, E_ST1, E_ST2, E_ST3, E_HOLD, E_BIT, E_SP0, E_SP1, E_SP2
  } eng_st_t;
endpackage

// File: rtl/i2c_mtx_tick.sv
module i2c_mtx_tick #(
  parameter int QDIV = 125
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt == CW'(QDIV - 1));
      if (cnt == CW'(QDIV - 1)) cnt <= '0;
      else                      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_mtx_buswatch.sv
module i2c_mtx_buswatch (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic s_scl,
  output logic s_sda,
  output logic busy
);
  logic p_scl, p_sda;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_scl <= 1'b1;
      s_sda <= 1'b1;
      p_scl <= 1'b1;
      p_sda <= 1'b1;
      busy  <= 1'b0;
    end else begin
      s_scl <= scl_in;
      s_sda <= sda_in;
      p_scl <= s_scl;
      p_sda <= s_sda;
      if (p_scl && s_scl && p_sda && !s_sda)      busy <= 1'b1;
      else if (p_scl && s_scl && !p_sda && s_sda) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_mtx_regs.sv
module i2c_mtx_regs
  import i2c_mtx_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_sel,
  input  logic [DW-1:0] reg_wdata,
  input  logic          post_v,
  input  logic [DW-1:0] post_code,
  input  logic          stop_done,
  input  logic          eng_idle,
  output logic          go,
  output logic          go_start,
  output logic          go_stop,
  output logic [DW-1:0] tx_byte,
  output logic          flag,
  output logic [DW-1:0] ctrl_rd,
  output logic [DW-1:0] status
);
  logic wcol, en, start_pend, stop_pend;
  logic ctrl_wr, data_wr, accept;

  assign ctrl_wr = reg_wr && !reg_sel;
  assign data_wr = reg_wr && reg_sel;
  assign accept  = ctrl_wr && reg_wdata[B_FLAG] && reg_wdata[B_EN] && (flag || eng_idle);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag       <= 1'b0;
      wcol       <= 1'b0;
      en         <= 1'b0;
      start_pend <= 1'b0;
      stop_pend  <= 1'b0;
      tx_byte    <= '0;
      status     <= ST_NONE;
      go         <= 1'b0;
      go_start   <= 1'b0;
      go_stop    <= 1'b0;
    end else begin
      go <= 1'b0;
      if (post_v) begin
        flag       <= 1'b1;
        status     <= post_code;
        start_pend <= 1'b0;
      end
      if (stop_done) stop_pend <= 1'b0;
      if (ctrl_wr) begin
        en <= reg_wdata[B_EN];
        if (accept) begin
          flag       <= 1'b0;
          status     <= ST_NONE;
          go         <= 1'b1;
          go_start   <= reg_wdata[B_START];
          go_stop    <= reg_wdata[B_STOP] && !reg_wdata[B_START];
          start_pend <= reg_wdata[B_START];
          stop_pend  <= reg_wdata[B_STOP] && !reg_wdata[B_START];
        end
      end
      if (data_wr) begin
        if (flag) begin
          tx_byte <= reg_wdata;
          wcol    <= 1'b0;
        end else begin
          wcol    <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    ctrl_rd          = '0;
    ctrl_rd[B_FLAG]  = flag;
    ctrl_rd[B_START] = start_pend;
    ctrl_rd[B_STOP]  = stop_pend;
    ctrl_rd[B_WCOL]  = wcol;
    ctrl_rd[B_EN]    = en;
  end
endmodule

// File: rtl/i2c_mtx_engine.sv
module i2c_mtx_engine
  import i2c_mtx_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          go,
  input  logic          go_start,
  input  logic          go_stop,
  input  logic [DW-1:0] tx_byte,
  input  logic          s_scl,
  input  logic          s_sda,
  input  logic          busy,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          post_v,
  output logic [DW-1:0] post_code,
  output logic          stop_done,
  output logic          eng_idle
);
  localparam int BCW = $clog2(DW + 1);
  localparam logic [BCW-1:0] ACK_BIT = BCW'(DW);

  eng_st_t        st;
  logic [1:0]     ph;
  logic [BCW-1:0] bitc;
  logic [DW-1:0]  sh;
  logic           rs, addr, acked;

  assign eng_idle = (st == E_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= E_IDLE;
      ph        <= '0;
      bitc      <= '0;
      sh        <= '0;
      rs        <= 1'b0;
      addr      <= 1'b0;
      acked     <= 1'b0;
      scl_oe    <= 1'b0;
      sda_oe    <= 1'b0;
      post_v    <= 1'b0;
      post_code <= ST_NONE;
      stop_done <= 1'b0;
    end else begin
      post_v    <= 1'b0;
      stop_done <= 1'b0;
      case (st)
        E_IDLE: begin
          scl_oe <= 1'b0;
          sda_oe <= 1'b0;
          if (go && go_start) begin
            st <= E_ST1;
            rs <= 1'b0;
          end else if (go && go_stop) begin
            stop_done <= 1'b1;
          end
        end
        E_RS0: if (tick) begin
          scl_oe <= 1'b0;
          st     <= E_ST1;
        end
        E_ST1: if (tick && s_scl && s_sda && (rs || !busy)) begin
          sda_oe <= 1'b1;
          st     <= E_ST2;
        end
        E_ST2: if (tick) begin
          scl_oe <= 1'b1;
          st     <= E_ST3;
        end
        E_ST3: if (tick) begin
          st        <= E_HOLD;
          addr      <= 1'b1;
          post_v    <= 1'b1;
          post_code <= ST_START;
        end
        E_HOLD: if (go) begin
          if (go_start) begin
            sda_oe <= 1'b0;
            rs     <= 1'b1;
            st     <= E_RS0;
          end else if (go_stop) begin
            sda_oe <= 1'b1;
            st     <= E_SP0;
          end else begin
            sh   <= tx_byte;
            bitc <= '0;
            ph   <= 2'd0;
            st   <= E_BIT;
          end
        end
        E_BIT: if (tick) begin
          case (ph)
            2'd0: begin
              sda_oe <= (bitc == ACK_BIT) ? 1'b0 : ~sh[DW-1];
              ph     <= 2'd1;
            end
            2'd1: begin
              scl_oe <= 1'b0;
              ph     <= 2'd2;
            end
            2'd2: begin
              ph <= 2'd3;
              if (bitc != ACK_BIT && !sda_oe && !s_sda && s_scl) begin
                scl_oe    <= 1'b0;
                sda_oe    <= 1'b0;
                st        <= E_IDLE;
                post_v    <= 1'b1;
                post_code <= ST_ARB;
              end
              if (bitc == ACK_BIT) acked <= !s_sda;
            end
            default: begin
              scl_oe <= 1'b1;
              if (bitc == ACK_BIT) begin
                st        <= E_HOLD;
                addr      <= 1'b0;
                post_v    <= 1'b1;
                post_code <= addr ? (acked ? ST_AACK : ST_ANACK)
                                  : (acked ? ST_DACK : ST_DNACK);
              end else begin
                bitc <= bitc + 1'b1;
                sh   <= {sh[DW-2:0], 1'b0};
                ph   <= 2'd0;
              end
            end
          endcase
        end
        E_SP0: if (tick) begin
          scl_oe <= 1'b0;
          st     <= E_SP1;
        end
        E_SP1: if (tick) begin
          sda_oe <= 1'b0;
          st     <= E_SP2;
        end
        E_SP2: if (tick) begin
          st        <= E_IDLE;
          stop_done <= 1'b1;
        end
        default: st <= E_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_mtx_ctrl.sv
module i2c_mtx_ctrl
  import i2c_mtx_pkg::*;
#(
  parameter int QDIV = 125
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_wr,
  input  logic       reg_sel,
  input  logic [7:0] reg_wdata,
  output logic [7:0] ctrl_rd,
  output logic [7:0] data_rd,
  output logic [7:0] status,
  output logic       irq,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe
);
  logic          tick, s_scl, s_sda, busy;
  logic          go, go_start, go_stop, post_v, stop_done, eng_idle;
  logic [DW-1:0] post_code, tx_byte;

  i2c_mtx_tick #(.QDIV(QDIV)) u_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  i2c_mtx_buswatch u_watch (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .s_scl(s_scl), .s_sda(s_sda), .busy(busy)
  );

  i2c_mtx_regs u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .post_v(post_v), .post_code(post_code),
    .stop_done(stop_done), .eng_idle(eng_idle), .go(go),
    .go_start(go_start), .go_stop(go_stop), .tx_byte(tx_byte),
    .flag(irq), .ctrl_rd(ctrl_rd), .status(status)
  );

  i2c_mtx_engine u_eng (
    .clk(clk), .rst(rst), .tick(tick), .go(go), .go_start(go_start),
    .go_stop(go_stop), .tx_byte(tx_byte), .s_scl(s_scl), .s_sda(s_sda),
    .busy(busy), .scl_oe(scl_oe), .sda_oe(sda_oe), .post_v(post_v),
    .post_code(post_code), .stop_done(stop_done), .eng_idle(eng_idle)
  );

  assign data_rd = tx_byte;
endmodule

// File: rtl/i2c_mtx_chk.sv
module i2c_mtx_chk (
  input logic       clk,
  input logic       rst,
  input logic       reg_wr,
  input logic       reg_sel,
  input logic       clr_bit,
  input logic       irq,
  input logic [7:0] status,
  input logic [7:0] data_rd,
  input logic       wcol_bit,
  input logic       stop_bit,
  input logic       scl_oe
);
  // R10: low status bits never set
  a_r10_status_low_zero: assert property (@(posedge clk) disable iff (rst)
    status[2:0] == 3'b000);

  // R7: late data write raises collision
  a_r7_wcol_on_late_write: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_sel && !irq) |=> wcol_bit);

  // R7: late data write leaves the data register alone
  a_r7_data_untouched: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_sel && !irq) |=> $stable(data_rd));

  // R6: flag falls only through a clear write
  a_r6_flag_holds: assert property (@(posedge clk) disable iff (rst)
    (irq && !(reg_wr && !reg_sel && clr_bit)) |=> irq);

  // R6: SCL held low while waiting on software
  a_r6_scl_held: assert property (@(posedge clk) disable iff (rst)
    (irq && status != 8'h38) |-> scl_oe);

  // R8: stop completion never raises the flag
  a_r8_stop_no_flag: assert property (@(posedge clk) disable iff (rst)
    $fell(stop_bit) |-> !irq);
endmodule

bind i2c_mtx_ctrl i2c_mtx_chk u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .clr_bit(reg_wdata[7]), .irq(irq), .status(status), .data_rd(data_rd),
  .wcol_bit(ctrl_rd[3]), .stop_bit(ctrl_rd[4]), .scl_oe(scl_oe)
);

// File: tb/tb_i2c_mtx_ctrl.sv
module tb_i2c_mtx_ctrl;
  localparam int QDIV = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst = 1'b1;
  logic       reg_wr = 1'b0, reg_sel = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] ctrl_rd, data_rd, status;
  logic       irq, scl_oe, sda_oe;
  logic       ack_low = 1'b0, arb_low = 1'b0, oth_low = 1'b0;
  logic       scl_line, sda_line;

  assign scl_line = !scl_oe;
  assign sda_line = !(sda_oe || ack_low || arb_low || oth_low);

  i2c_mtx_ctrl #(.QDIV(QDIV)) dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ctrl_rd(ctrl_rd), .data_rd(data_rd),
    .status(status), .irq(irq), .scl_in(scl_line), .sda_in(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  int n_chk = 0, n_err = 0;
  int err_r10 = 0, err_r6_drop = 0, err_r6_scl = 0;
  int n_start = 0, n_stop = 0, last_hi = 0, cyc = 0, hi_start = 0;
  int bitcnt = 0, nbyte = 0;
  bit after_start = 0, ack_mode = 0, arb_armed = 0, mdl_flag = 0;
  int arb_byte = 0, arb_bit = 0;
  logic [7:0] shreg = 0;
  logic [7:0] rxq[$];
  logic pscl = 1'b1, psda = 1'b1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // behavioural bus model and per-clock reference comparison
  always begin
    @(posedge clk);
    #5;
    cyc++;
    if (!rst) begin
      if (status[2:0] != 3'b000 || (!irq && status != 8'hF8)) err_r10++;
      if (irq) mdl_flag = 1;
      else if (mdl_flag) begin
        err_r6_drop++;
        mdl_flag = 0;
      end
      if (irq && status != 8'h38 && !scl_oe) err_r6_scl++;
      if (pscl && scl_line && psda && !sda_line) begin
        n_start++; bitcnt = 0; nbyte = 0; after_start = 1; ack_low = 0;
      end
      if (pscl && scl_line && !psda && sda_line) n_stop++;
      if (!pscl && scl_line) begin
        hi_start = cyc;
        if (bitcnt < 8) shreg = {shreg[6:0], sda_line};
      end
      if (pscl && !scl_line) begin
        if (after_start) after_start = 0;
        else begin
          last_hi = cyc - hi_start;
          bitcnt++;
          if (bitcnt == 8) begin
            rxq.push_back(shreg);
            ack_low = ack_mode;
          end else if (bitcnt == 9) begin
            ack_low = 0; bitcnt = 0; nbyte++;
          end
          if (arb_armed && nbyte == arb_byte && bitcnt == arb_bit) begin
            arb_low = 1; arb_armed = 0;
          end
        end
      end
    end
    pscl = scl_line;
    psda = sda_line;
  end

  task automatic wr_reg(input bit sel, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    if (!sel && d[7] && d[2] && irq) mdl_flag = 0;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_flag(input string req);
    int n = 0;
    while (!irq && n < 4000) begin
      @(negedge clk);
      n++;
    end
    if (!irq) chk(0, req, 0, 1);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit ack,
                           input logic [7:0] code, input string req);
    logic [7:0] got;
    ack_mode = ack;
    wr_reg(1'b1, b);
    wr_reg(1'b0, 8'h84);
    wait_flag(req);
    @(negedge clk);
    chk(status == code, {req, " status"}, status, code);
    got = (rxq.size() > 0) ? rxq.pop_front() : 8'hxx;
    chk(got === b, {req, " byte on wire"}, got, b);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog (all requirements) actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int st0, sp0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(irq == 0, "R1 flag", irq, 0);
    chk(status == 8'hF8, "R1 status", status, 8'hF8);
    chk(scl_oe == 0 && sda_oe == 0, "R1 enables", {scl_oe, sda_oe}, 0);
    chk(ctrl_rd == 8'h00, "R1 ctrl", ctrl_rd, 0);

    // R7 data write with flag low is discarded
    wr_reg(1'b1, 8'h5A);
    chk(ctrl_rd[3] == 1, "R7 collision set", ctrl_rd[3], 1);
    chk(data_rd == 8'h00, "R7 data kept", data_rd, 0);

    // R2 command without enable is ignored
    wr_reg(1'b0, 8'hA0);
    repeat (20 * QDIV) @(negedge clk);
    chk(irq == 0 && scl_oe == 0 && sda_oe == 0 && n_start == 0,
        "R2 no enable ignored", n_start, 0);

    // R2 START
    wr_reg(1'b0, 8'hA4);
    wait_flag("R2 start flag");
    @(negedge clk);
    chk(status == 8'h08, "R2 status", status, 8'h08);
    chk(n_start == 1, "R2 start seen", n_start, 1);
    repeat (10 * QDIV) @(negedge clk);
    chk(irq == 1 && scl_oe == 1, "R6 held while flag high", {irq, scl_oe}, 2'b11);

    // R7 legal data write clears collision
    wr_reg(1'b1, 8'hA6);
    chk(ctrl_rd[3] == 0 && data_rd == 8'hA6, "R7 legal write", data_rd, 8'hA6);
    ack_mode = 1;
    wr_reg(1'b0, 8'h84);
    chk(irq == 0, "R6 flag cleared by one", irq, 0);
    wait_flag("R4 addr");
    @(negedge clk);
    chk(status == 8'h18, "R4 addr ACK status", status, 8'h18);
    chk(rxq.size() > 0 && rxq[0] == 8'hA6, "R4 addr byte", rxq.size() > 0 ? rxq[0] : 0, 8'hA6);
    void'(rxq.pop_front());

    send_byte(8'h3C, 1'b1, 8'h28, "R5 data ACK");
    chk(last_hi == 2 * QDIV, "R11 SCL high width", last_hi, 2 * QDIV);
    send_byte(8'hC5, 1'b0, 8'h30, "R5 data NACK");

    // R8 STOP
    sp0 = n_stop;
    wr_reg(1'b0, 8'h94);
    chk(ctrl_rd[4] == 1, "R8 stop bit pending", ctrl_rd[4], 1);
    begin
      int n = 0;
      while (ctrl_rd[4] && n < 200) begin @(negedge clk); n++; end
    end
    chk(ctrl_rd[4] == 0, "R8 stop bit self-clears", ctrl_rd[4], 0);
    repeat (10 * QDIV) @(negedge clk);
    chk(n_stop == sp0 + 1, "R8 stop seen", n_stop, sp0 + 1);
    chk(irq == 0 && scl_oe == 0 && sda_oe == 0, "R8 no flag, lines free", irq, 0);

    // R3 another master owns the bus
    oth_low = 1'b1;
    repeat (5) @(negedge clk);
    st0 = n_start;
    wr_reg(1'b0, 8'hA4);
    repeat (20 * QDIV) @(negedge clk);
    chk(scl_oe == 0 && sda_oe == 0 && irq == 0, "R3 held off", {scl_oe, sda_oe, irq}, 0);
    chk(n_start == st0, "R3 no own start", n_start, st0);
    oth_low = 1'b0;
    wait_flag("R3 start after free");
    @(negedge clk);
    chk(status == 8'h08, "R3 start status", status, 8'h08);

    send_byte(8'h40, 1'b0, 8'h20, "R4 addr NACK");

    // R9 arbitration loss at bit 1 of the data byte
    arb_byte = 1; arb_bit = 1; arb_armed = 1; ack_mode = 0;
    wr_reg(1'b1, 8'hF0);
    wr_reg(1'b0, 8'h84);
    wait_flag("R9 loss");
    @(negedge clk);
    chk(status == 8'h38, "R9 status", status, 8'h38);
    chk(scl_oe == 0 && sda_oe == 0, "R9 lines released", {scl_oe, sda_oe}, 0);
    arb_low = 1'b0;
    repeat (10 * QDIV) @(negedge clk);
    wr_reg(1'b0, 8'hA4);
    wait_flag("R9 restart");
    @(negedge clk);
    chk(status == 8'h08, "R9 restart status", status, 8'h08);
    wr_reg(1'b0, 8'h94);
    repeat (20 * QDIV) @(negedge clk);
    chk(irq == 0 && scl_oe == 0 && sda_oe == 0, "R8 final stop", irq, 0);

    chk(err_r10 == 0, "R10 status low bits / idle code", err_r10, 0);
    chk(err_r6_drop == 0, "R6 flag never drops alone", err_r6_drop, 0);
    chk(err_r6_scl == 0, "R6 SCL held low while waiting", err_r6_scl, 0);
    finish_run();
  end
endmodule